// File: doc/BRIEF.md
# Per-Instance Deadline Miss Monitor

This block watches one data writer and checks that each of its instances is refreshed at least once in every deadline window. A writer is either keyed, with up to `NUM_SLOTS` instances addressed by a slot index, or keyless, with one implicit instance. The first write to a slot registers it and captures its 128-bit handle. Every later write marks the slot as refreshed for the current window.

A free-running time value is compared with an internal boundary register. The windows are `[k*PERIOD, (k+1)*PERIOD)`. When time reaches a boundary, every registered slot that was not refreshed in the window that just closed counts as one miss. The block keeps a cumulative miss total, a count of misses since the last read, and the handle of the most recent offender. A sticky flag shows that misses are pending. A read request streams a six-word status record over a ready/valid port with a last-word marker, and the read clears the flag and the since-read count.

Top module: `deadline_miss_monitor`

## Requirements
- R1: After reset, miss_flag_o and rd_valid_o are 0, and a first read returns total 0, change 0 and an all-zero handle.
- R2: Boundaries fall at PERIOD, 2*PERIOD, and so on. A boundary is evaluated in the cycle where time_i is greater than or equal to the pending boundary, and it is not evaluated earlier.
- R3: Each registered slot that was not written in the closed window adds exactly one to the total. Two stale slots at one boundary add two.
- R4: A slot written inside the closed window does not miss. A registered slot that is never written again misses at every later boundary.
- R5: A write in the same cycle as a boundary evaluation counts toward the following window, not the closed one.
- R6: No miss is recorded while no slot has been registered.
- R7: miss_flag_o rises in the cycle after a boundary that records a miss. It stays high until a read starts and is 0 afterwards, unless another miss arrives.
- R8: A read returns six words, each WORD_W wide, in this order: total, change, handle[31:0], handle[63:32], handle[95:64], handle[127:96]. rd_last_o is high only on the sixth word. A word advances only on an edge where rd_valid_o and rd_ready_i are both high.
- R9: The change count returns to zero when a read starts, while the total keeps accumulating.
- R10: The reported handle is taken from the highest-indexed slot that missed at the latest boundary with misses.
- R11: If time jumps past k boundaries, k evaluations happen, one per cycle, on k consecutive edges.
- R12: With KEYED=0, the block tracks one instance, ignores wr_slot_i, and always reports an all-zero handle.
- R13: A read request made while a record is streaming is ignored, and no second record follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | TIME_W | Current time, non-decreasing |
| wr_i | input | 1 | Write strobe for one instance |
| wr_slot_i | input | SLOT_W | Slot index of the write (keyed only) |
| wr_handle_i | input | 4*WORD_W | Handle captured on a slot's first write |
| rd_req_i | input | 1 | Request a status record |
| rd_ready_i | input | 1 | Consumer accepts the current word |
| rd_valid_o | output | 1 | Status word valid |
| rd_data_o | output | WORD_W | Status word |
| rd_last_o | output | 1 | Marks the sixth word |
| miss_flag_o | output | 1 | Misses pending since the last read |

## Verification
A boundary is evaluated on the first edge where time_i has reached it. Counters, flag and handle are updated on that same edge, so miss_flag_o shows the result one cycle after time_i is driven. A jump over k boundaries needs k further edges. The first status word is valid one edge after the request. The bench changes time and write inputs just after an edge and waits at least two cycles before sampling the flag, with a longer wait after a multi-boundary jump. During a read it toggles rd_ready_i and samples data and last on the falling edge, before the edge that consumes the word.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  localparam int unsigned HANDLE_WORDS = 4;
  localparam int unsigned REC_WORDS    = HANDLE_WORDS + 2;

  typedef enum logic {
    RO_IDLE,
    RO_STREAM
  } ro_state_e;
endpackage

// File: rtl/dmm_boundary.sv
module dmm_boundary #(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned PERIOD = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  output logic              tick_o
);
  localparam logic [TIME_W-1:0] STEP = TIME_W'(PERIOD);

  logic [TIME_W-1:0] next_q;

  assign tick_o = (time_i >= next_q);

  // one boundary per cycle; a large jump drains over consecutive cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     next_q <= STEP;
    else if (tick_o) next_q <= next_q + STEP;
  end

  a_r2_boundary_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(next_q));
endmodule

// File: rtl/dmm_slot_table.sv
module dmm_slot_table #(
  parameter int unsigned SLOTS  = 3,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned HW     = 128,
  parameter bit          KEYED  = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [SLOT_W-1:0]         wr_slot_i,
  input  logic [HW-1:0]             wr_handle_i,
  input  logic                      tick_i,
  output logic [SLOTS-1:0]          miss_vec_o,
  output logic [SLOTS-1:0][HW-1:0]  handle_o
);
  logic [SLOTS-1:0] reg_q, fresh_q, hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (KEYED) begin : g_keyed
      logic [HW-1:0] handle_q;
      assign hit[s] = wr_i && (wr_slot_i == SLOT_W'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 handle_q <= '0;
        else if (hit[s] && !reg_q[s]) handle_q <= wr_handle_i;
      end
      assign handle_o[s] = handle_q;
    end else begin : g_keyless
      assign hit[s]      = wr_i;
      assign handle_o[s] = '0;
    end

    // a write in the evaluation cycle belongs to the next window
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[s]   <= 1'b0;
        fresh_q[s] <= 1'b0;
      end else if (hit[s]) begin
        reg_q[s]   <= 1'b1;
        fresh_q[s] <= 1'b1;
      end else if (tick_i) begin
        fresh_q[s] <= 1'b0;
      end
    end

    assign miss_vec_o[s] = reg_q[s] & ~fresh_q[s];
  end

  a_r4_reg_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_q & $past(reg_q)) == $past(reg_q)));
  a_r6_no_miss_unreg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_q == '0) |-> (miss_vec_o == '0));
endmodule

// File: rtl/dmm_readout.sv
module dmm_readout
  import dmm_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [WORD_W-1:0]              total_i,
  input  logic [WORD_W-1:0]              change_i,
  input  logic [HANDLE_WORDS*WORD_W-1:0] handle_i,
  input  logic                           ready_i,
  output logic                           valid_o,
  output logic [WORD_W-1:0]              data_o,
  output logic                           last_o,
  output logic                           busy_o
);
  localparam int unsigned IDX_W = $clog2(REC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

  ro_state_e                           state_q;
  logic [IDX_W-1:0]                    idx_q;
  logic [REC_WORDS-1:0][WORD_W-1:0]    words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RO_IDLE;
      idx_q   <= '0;
      words_q <= '0;
    end else if (state_q == RO_IDLE) begin
      if (start_i) begin
        state_q    <= RO_STREAM;
        idx_q      <= '0;
        words_q[0] <= total_i;
        words_q[1] <= change_i;
        for (int w = 0; w < HANDLE_WORDS; w++)
          words_q[w+2] <= handle_i[w*WORD_W +: WORD_W];
      end
    end else if (ready_i) begin
      if (idx_q == LAST_IDX) state_q <= RO_IDLE;
      else                   idx_q   <= idx_q + 1'b1;
    end
  end

  assign valid_o = (state_q == RO_STREAM);
  assign busy_o  = valid_o;
  assign data_o  = words_q[idx_q];
  assign last_o  = valid_o && (idx_q == LAST_IDX);

  a_r8_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(idx_q)));
  a_r13_snapshot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !(ready_i && last_o)) |=> $stable(words_q));
endmodule

// File: rtl/deadline_miss_monitor.sv
module deadline_miss_monitor
  import dmm_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3,
  parameter bit          KEYED     = 1'b1,
  parameter int unsigned TIME_W    = 32,
  parameter int unsigned PERIOD    = 1000,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned HW       = HANDLE_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [HW-1:0]     wr_handle_i,
  input  logic              rd_req_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic              miss_flag_o
);
  localparam int unsigned SLOTS = KEYED ? NUM_SLOTS : 1;

  logic                      tick, busy, rd_start;
  logic [SLOTS-1:0]          miss_vec;
  logic [SLOTS-1:0][HW-1:0]  handles;
  logic [WORD_W-1:0]         total_q, change_q, add_c;
  logic [HW-1:0]             last_handle_q, hit_handle_c;
  logic                      flag_q, any_c;

  dmm_boundary #(.TIME_W(TIME_W), .PERIOD(PERIOD)) u_boundary (
    .clk_i, .rst_ni, .time_i, .tick_o(tick)
  );

  dmm_slot_table #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .HW(HW), .KEYED(KEYED)) u_slots (
    .clk_i, .rst_ni, .wr_i, .wr_slot_i, .wr_handle_i,
    .tick_i(tick), .miss_vec_o(miss_vec), .handle_o(handles)
  );

  assign rd_start = rd_req_i && !busy;

  // ascending scan: the highest missing slot supplies the handle
  always_comb begin
    add_c        = '0;
    any_c        = 1'b0;
    hit_handle_c = last_handle_q;
    for (int s = 0; s < SLOTS; s++) begin
      if (tick && miss_vec[s]) begin
        add_c        = add_c + 1'b1;
        any_c        = 1'b1;
        hit_handle_c = handles[s];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q       <= '0;
      change_q      <= '0;
      flag_q        <= 1'b0;
      last_handle_q <= '0;
    end else begin
      total_q       <= total_q + add_c;
      change_q      <= (rd_start ? '0 : change_q) + add_c;
      flag_q        <= any_c || (flag_q && !rd_start);
      last_handle_q <= hit_handle_c;
    end
  end

  dmm_readout #(.WORD_W(WORD_W)) u_readout (
    .clk_i, .rst_ni, .start_i(rd_start),
    .total_i(total_q), .change_i(change_q), .handle_i(last_handle_q),
    .ready_i(rd_ready_i), .valid_o(rd_valid_o), .data_o(rd_data_o),
    .last_o(rd_last_o), .busy_o(busy)
  );

  assign miss_flag_o = flag_q;

  a_r7_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start && !tick) |=> !miss_flag_o);
  a_r9_change_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_q <= total_q);
  a_r3_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (total_q - $past(total_q)) <= WORD_W'(SLOTS));
endmodule

// File: tb/deadline_miss_monitor_bench.sv
`timescale 1ns/1ps
module deadline_miss_monitor_bench;
  localparam int unsigned WW = 32;
  localparam int unsigned HW = 128;
  localparam logic [HW-1:0] H0 = 128'h0a0a0a0a_11111111_22222222_33333333;
  localparam logic [HW-1:0] H1 = 128'h1b1b1b1b_44444444_55555555_66666666;
  localparam logic [HW-1:0] H2 = 128'h2c2c2c2c_77777777_88888888_99999999;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tm = '0;
  logic wr_a = 0, wr_b = 0, rq_a = 0, rq_b = 0, rdy = 0;
  logic [1:0] slot_a = '0, slot_b = '0;
  logic [HW-1:0] hd_a = '0, hd_b = '0;
  logic va, vb, la, lb, fa, fb;
  logic [WW-1:0] da, db;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  deadline_miss_monitor #(.NUM_SLOTS(3), .KEYED(1'b1), .PERIOD(10)) u_deadline_miss_monitor (
    .clk_i(clk), .rst_ni(rst_n), .time_i(tm), .wr_i(wr_a), .wr_slot_i(slot_a),
    .wr_handle_i(hd_a), .rd_req_i(rq_a), .rd_ready_i(rdy), .rd_valid_o(va),
    .rd_data_o(da), .rd_last_o(la), .miss_flag_o(fa)
  );

  deadline_miss_monitor #(.NUM_SLOTS(3), .KEYED(1'b0), .PERIOD(20)) u_keyless (
    .clk_i(clk), .rst_ni(rst_n), .time_i(tm), .wr_i(wr_b), .wr_slot_i(slot_b),
    .wr_handle_i(hd_b), .rd_req_i(rq_b), .rd_ready_i(rdy), .rd_valid_o(vb),
    .rd_data_o(db), .rd_last_o(lb), .miss_flag_o(fb)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_time(logic [31:0] t, int settle);
    @(posedge clk); #1 tm = t;
    cycles(settle);
    #1;
  endtask

  task automatic write_a(logic [1:0] s, logic [HW-1:0] h, logic [31:0] t);
    @(posedge clk); #1 wr_a = 1; slot_a = s; hd_a = h; tm = t;
    @(posedge clk); #1 wr_a = 0;
    cycles(2); #1;
  endtask

  task automatic write_b(logic [1:0] s, logic [HW-1:0] h);
    @(posedge clk); #1 wr_b = 1; slot_b = s; hd_b = h;
    @(posedge clk); #1 wr_b = 0;
  endtask

  // reads a record with a stalling consumer and a stray request mid-stream
  task automatic read_rec(bit use_b, logic [31:0] et, logic [31:0] ec,
                          logic [HW-1:0] eh, string req);
    logic [WW-1:0] exp_w [6];
    int got = 0;
    exp_w[0] = et; exp_w[1] = ec;
    for (int w = 0; w < 4; w++) exp_w[w+2] = eh[w*32 +: 32];
    @(posedge clk); #1 rdy = 0;
    if (use_b) rq_b = 1; else rq_a = 1;
    @(posedge clk); #1 rq_a = 0; rq_b = 0;
    for (int cyc = 0; cyc < 40 && got < 6; cyc++) begin
      @(posedge clk); #1 rdy = cyc[0];
      if (cyc == 3) begin if (use_b) rq_b = 1; else rq_a = 1; end
      else begin rq_a = 0; rq_b = 0; end
      @(negedge clk);
      if ((use_b ? vb : va) && rdy) begin
        check($sformatf("%s R8 word%0d", req, got), use_b ? db : da, exp_w[got]);
        check($sformatf("R8 last on word%0d", got), use_b ? lb : la, got == 5);
        got++;
      end
    end
    check("R8 six words delivered", got, 6);
    @(posedge clk); #1 rdy = 1; rq_a = 0; rq_b = 0;
    cycles(3); #1;
    check("R13 no second record", use_b ? vb : va, 0);
    rdy = 0;
  endtask

  task automatic t_reset;
    check("R1 flag after reset", fa, 0);
    check("R1 valid after reset", va, 0);
    read_rec(0, 0, 0, '0, "R1 empty record");
  endtask

  task automatic t_no_reg;
    set_time(10, 2);
    check("R6 no miss without instances", fa, 0);
  endtask

  task automatic t_refreshed;
    write_a(0, H0, 12);
    write_a(1, H1, 12);
    write_b(2, 128'hdead);
    set_time(19, 2);
    check("R2 no evaluation before boundary", fa, 0);
    set_time(20, 2);
    check("R4 refreshed slots do not miss", fa, 0);
    check("R12 keyless refreshed no miss", fb, 0);
  endtask

  task automatic t_single_miss;
    write_a(0, H0, 22);
    set_time(30, 2);
    check("R2 miss at boundary 30", fa, 1);
    cycles(3); #1;
    check("R7 flag held", fa, 1);
    read_rec(0, 1, 1, H1, "R10 single miss");
    check("R7 flag cleared by read", fa, 0);
  endtask

  task automatic t_write_at_boundary;
    write_a(1, H1, 40);
    check("R3 two misses raise flag", fa, 1);
    check("R12 keyless miss at 40", fb, 1);
    read_rec(0, 3, 2, H1, "R3 R10 two stale slots");
    set_time(50, 2);
    check("R5 flag after boundary 50", fa, 1);
    read_rec(0, 4, 1, H0, "R5 R9 boundary write");
  endtask

  task automatic t_jump;
    write_a(2, H2, 52);
    set_time(85, 2);
    set_time(85, 4);
    check("R11 flag after jump", fa, 1);
    read_rec(0, 12, 8, H2, "R11 R4 three boundaries");
    check("R9 change cleared flag", fa, 0);
  endtask

  task automatic t_keyless;
    read_rec(1, 3, 3, '0, "R12 keyless nil handle");
    check("R12 keyless flag cleared", fb, 0);
  endtask

  initial begin
    cycles(3);
    #1 rst_n = 1;
    cycles(1); #1;
    t_reset;
    t_no_reg;
    t_refreshed;
    t_single_miss;
    t_write_at_boundary;
    t_jump;
    t_keyless;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycles(20000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule